// File: doc/BRIEF.md
# 64-bit Tick Timer with Snapshot High Word

This block is an operating-system time base: a free-running up-counter that advances on every cycle in which the timer tick input is high and the run enable is on. Software reaches it through a small word-addressed register bus. Every read returns its data one cycle after the request.

The counter is wider than the bus, so software reads it in two halves. A read of the low half also copies the counter's upper 32 bits, taken in the same cycle, into a snapshot register. Reading the snapshot afterwards gives a consistent 64-bit value, even if the low half has wrapped in between. There is only one snapshot register for all readers. If a second reader reads the low half in between, it overwrites the snapshot, and the first reader can then see a value exactly 2^32 too high.

A compare register and a mode bit select between two behaviours: the counter either restarts at zero when it reaches the compare value, or runs on past it. A sticky match flag records each compare hit. A build parameter reduces the counter to 32 bits, read through the high-count address only.

Top module: `tick_timer64`

## Requirements
- R1: After reset the counter, the snapshot register, the run enable and the match flag are 0, the mode bit is 0 (restart at compare), the compare register is 0xFFFFFFFF and rdata_o is 0.
- R2: While the run enable is 1, the counter increases by exactly 1 on each clock edge where tick_i is 1. It holds its value when tick_i is 0 or when the run enable is 0.
- R3: A read request (req_i=1, we_i=0) returns the addressed register on rdata_o after the next clock edge. Word addresses are: 0 count low, 1 count high, 2 snapshot, 3 control, 4 compare, 5 enable-set, 6 enable-clear, 7 enable-status.
- R4: A read of address 0 copies the counter's upper 32 bits, from the same cycle, into the snapshot register, which reads back at address 2. Reads of any other address leave the snapshot unchanged.
- R5: A later read of address 0 overwrites the snapshot. An interleaved reader can therefore pair an old low word with a newer high word.
- R6: A write to address 0 or 1 loads wdata_i into the low or high 32 bits of the counter. A load takes priority over an increment in the same cycle.
- R7: Control bit 15 is the mode bit. When it is 0, a tick taken while the counter equals the zero-extended compare value sets the counter to 0. When it is 1, the counter continues upward past the compare value.
- R8: Control bits 7:6 are storage bits. They read back as written and do not change counting.
- R9: Writing 1 to bit 15 of address 5 sets the run enable, and writing 1 to bit 15 of address 6 clears it. Writing 0 there, or writing any other bit of those registers, has no effect. Address 7 reports the enable in bit 15.
- R10: Control bit 16 is the match flag. It is set by each enabled tick taken while the counter equals the compare value. Writing 1 to bit 16 of the control register clears it; writing 0 there leaves it set.
- R11: With WIDE=0 the counter is 32 bits wide and is read and written at address 1. Address 0 reads 0 and takes no snapshot, and address 2 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer tick qualifier |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |

## Verification
The bench targets the carry out of the low half. A design that latched the high word late, or from the wrong half, would return a snapshot one too high or stale after a wrap. The torn two-reader sequence is replayed to show that the pair read is exactly 2^32 high; a design with a buffer per reader would hide this. Compare restart is checked over several periods and with the mode bit set: an off-by-one restart ends on a different count, and a free-running mode that ignored the bit would also restart. Write-versus-tick collisions, zero writes to the set and clear registers, and the clear-by-one flag each catch a design that got the priority or the polarity backwards.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [2:0] {
    A_CNT_LO = 3'd0,
    A_CNT_HI = 3'd1,
    A_SNAP   = 3'd2,
    A_CTRL   = 3'd3,
    A_CMP    = 3'd4,
    A_EN_SET = 3'd5,
    A_EN_CLR = 3'd6,
    A_EN_ST  = 3'd7
  } reg_addr_e;

  localparam int unsigned MODE_BIT = 15;
  localparam int unsigned AUX_LSB  = 6;
  localparam int unsigned AUX_W    = 2;
  localparam int unsigned FLAG_BIT = 16;
  localparam int unsigned EN_BIT   = 15;
endpackage

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             free_i,
  input  logic [BUS_W-1:0] cmp_i,
  input  logic             ld_lo_i,
  input  logic             ld_hi_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [CW-1:0]    cnt_o,
  output logic             hit_o
);
  localparam int unsigned HI_LSB = CW - BUS_W;

  logic [CW-1:0] cnt_q, cnt_d, cmp_ext;
  logic          at_cmp, restart;

  assign cmp_ext = CW'(cmp_i);
  assign at_cmp  = (cnt_q == cmp_ext);
  assign restart = at_cmp && !free_i;

  always_comb begin
    cnt_d = cnt_q;
    if (run_i) cnt_d = restart ? '0 : cnt_q + 1'b1;
    // software load beats the tick
    if (ld_lo_i) cnt_d[BUS_W-1:0] = wdata_i;
    if (ld_hi_i) cnt_d[HI_LSB +: BUS_W] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign hit_o = run_i && at_cmp;

  assert_load_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_lo_i |=> cnt_q[BUS_W-1:0] == $past(wdata_i));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ld_lo_i && !ld_hi_i) |=> $stable(cnt_q));
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !restart && !ld_lo_i && !ld_hi_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && restart && !ld_lo_i && !ld_hi_i) |=> cnt_q == '0);
endmodule

// File: rtl/tmr_snap.sv
module tmr_snap
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [BUS_W-1:0] hi_i,
  output logic [BUS_W-1:0] snap_o
);
  logic [BUS_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    snap_q <= '0;
    else if (cap_i) snap_q <= hi_i;
  end

  assign snap_o = snap_q;

  assert_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> snap_o == $past(hi_i));
  assert_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(snap_o));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctrl_i,
  input  logic             wr_cmp_i,
  input  logic             wr_en_set_i,
  input  logic             wr_en_clr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             hit_i,
  output logic             free_o,
  output logic [AUX_W-1:0] aux_o,
  output logic             flag_o,
  output logic [BUS_W-1:0] cmp_o,
  output logic             en_o
);
  logic             free_q, flag_q, en_q;
  logic [AUX_W-1:0] aux_q;
  logic [BUS_W-1:0] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= 1'b0;
      aux_q  <= '0;
      flag_q <= 1'b0;
      cmp_q  <= '1;
      en_q   <= 1'b0;
    end else begin
      if (wr_ctrl_i) begin
        free_q <= wdata_i[MODE_BIT];
        aux_q  <= wdata_i[AUX_LSB +: AUX_W];
      end
      // a new hit outranks a same-cycle clear
      if (hit_i)                               flag_q <= 1'b1;
      else if (wr_ctrl_i && wdata_i[FLAG_BIT]) flag_q <= 1'b0;
      if (wr_cmp_i) cmp_q <= wdata_i;
      if (wr_en_set_i && wdata_i[EN_BIT])      en_q <= 1'b1;
      else if (wr_en_clr_i && wdata_i[EN_BIT]) en_q <= 1'b0;
    end
  end

  assign free_o = free_q;
  assign aux_o  = aux_q;
  assign flag_o = flag_q;
  assign cmp_o  = cmp_q;
  assign en_o   = en_q;

  assert_flag_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> flag_o);
  assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !(wr_ctrl_i && wdata_i[FLAG_BIT])) |=> flag_o);
  assert_en_zero_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_en_set_i || wr_en_clr_i) && !wdata_i[EN_BIT]) |=> $stable(en_o));
  assert_en_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_clr_i && wdata_i[EN_BIT]) |=> !en_o);
endmodule

// File: rtl/tick_timer64.sv
module tick_timer64
  import tmr_pkg::*;
#(
  parameter bit WIDE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o
);
  localparam int unsigned CW     = WIDE ? 64 : 32;
  localparam int unsigned HI_LSB = CW - BUS_W;

  logic             rd, wr;
  logic             wr_lo, wr_hi, rd_lo;
  logic             free, flag, en, hit;
  logic [AUX_W-1:0] aux;
  logic [BUS_W-1:0] cmp, snap, ctrl_rd, rd_mux, rdata_q;
  logic [CW-1:0]    cnt;

  assign rd    = req_i && !we_i;
  assign wr    = req_i && we_i;
  assign rd_lo = rd && (addr_i == A_CNT_LO) && WIDE;
  assign wr_lo = wr && (addr_i == A_CNT_LO) && WIDE;
  assign wr_hi = wr && (addr_i == A_CNT_HI);

  tmr_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_ctrl_i   (wr && (addr_i == A_CTRL)),
    .wr_cmp_i    (wr && (addr_i == A_CMP)),
    .wr_en_set_i (wr && (addr_i == A_EN_SET)),
    .wr_en_clr_i (wr && (addr_i == A_EN_CLR)),
    .wdata_i     (wdata_i),
    .hit_i       (hit),
    .free_o      (free),
    .aux_o       (aux),
    .flag_o      (flag),
    .cmp_o       (cmp),
    .en_o        (en)
  );

  tmr_count #(.CW(CW)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (en && tick_i),
    .free_i  (free),
    .cmp_i   (cmp),
    .ld_lo_i (wr_lo),
    .ld_hi_i (wr_hi),
    .wdata_i (wdata_i),
    .cnt_o   (cnt),
    .hit_o   (hit)
  );

  if (WIDE) begin : g_snap
    tmr_snap u_snap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (rd_lo),
      .hi_i   (cnt[HI_LSB +: BUS_W]),
      .snap_o (snap)
    );
  end else begin : g_no_snap
    assign snap = '0;
  end

  always_comb begin
    ctrl_rd                      = '0;
    ctrl_rd[FLAG_BIT]            = flag;
    ctrl_rd[MODE_BIT]            = free;
    ctrl_rd[AUX_LSB +: AUX_W]    = aux;
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      A_CNT_LO: rd_mux = WIDE ? cnt[BUS_W-1:0] : '0;
      A_CNT_HI: rd_mux = cnt[HI_LSB +: BUS_W];
      A_SNAP:   rd_mux = snap;
      A_CTRL:   rd_mux = ctrl_rd;
      A_CMP:    rd_mux = cmp;
      A_EN_ST:  rd_mux[EN_BIT] = en;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  assert_rd_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
  assert_cnt_rd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == A_CNT_HI) |=> rdata_o == $past(cnt[HI_LSB +: BUS_W]));
endmodule

// File: tb/sim_tick_timer64.sv
`timescale 1ns/1ps
module sim_tick_timer64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req0 = 1'b0, req1 = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  int          n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  tick_timer64 #(.WIDE(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req0), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata0));

  tick_timer64 #(.WIDE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req1), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1));

  // {we, addr, wdata, expected}
  localparam int NV = 14;
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 3'd1, 32'h0000_0007, 32'h0},
    {1'b1, 3'd0, 32'h0000_0005, 32'h0},
    {1'b0, 3'd0, 32'h0,         32'h0000_0005},
    {1'b0, 3'd2, 32'h0,         32'h0000_0007},
    {1'b1, 3'd1, 32'h0000_0009, 32'h0},
    {1'b0, 3'd2, 32'h0,         32'h0000_0007},
    {1'b0, 3'd1, 32'h0,         32'h0000_0009},
    {1'b1, 3'd3, 32'h0000_80C0, 32'h0},
    {1'b0, 3'd3, 32'h0,         32'h0000_80C0},
    {1'b1, 3'd3, 32'h0000_0040, 32'h0},
    {1'b0, 3'd3, 32'h0,         32'h0000_0040},
    {1'b1, 3'd4, 32'h0000_1234, 32'h0},
    {1'b0, 3'd4, 32'h0,         32'h0000_1234},
    {1'b0, 3'd7, 32'h0,         32'h0}
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic bus(input bit sel, input bit w, input logic [2:0] a,
                     input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    we = w; addr = a; wdata = d;
    if (sel) req1 = 1'b1; else req0 = 1'b1;
    @(posedge clk);
    #1 q = sel ? rdata1 : rdata0;
    @(negedge clk);
    req0 = 1'b0; req1 = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input bit sel, input logic [2:0] a, input logic [31:0] d);
    logic [31:0] q;
    bus(sel, 1'b1, a, d, q);
  endtask

  task automatic rd(input bit sel, input logic [2:0] a, input string rq, input logic [31:0] exp);
    logic [31:0] q;
    bus(sel, 1'b0, a, 32'h0, q);
    check(rq, q, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] q, a_lo, a_hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 rdata", rdata0, 32'h0);
    rd(0, 3'd0, "R1 cnt lo", 32'h0);
    rd(0, 3'd1, "R1 cnt hi", 32'h0);
    rd(0, 3'd2, "R1 snap", 32'h0);
    rd(0, 3'd3, "R1 ctrl", 32'h0);
    rd(0, 3'd4, "R1 cmp", 32'hFFFF_FFFF);
    rd(0, 3'd7, "R1 enable", 32'h0);

    // R3 R4 R6 R8 table walk
    for (int i = 0; i < NV; i++) begin
      bus(0, VEC[i][67], VEC[i][66:64], VEC[i][63:32], q);
      if (!VEC[i][67]) check("R3/R4/R8 table", q, VEC[i][31:0]);
    end

    // R2 counting and hold
    wr(0, 3'd3, 32'h0000_8000);
    wr(0, 3'd0, 32'h0); wr(0, 3'd1, 32'h0);
    wr(0, 3'd5, 32'h0000_8000);
    ticks(10);
    rd(0, 3'd0, "R2 count 10", 32'd10);
    repeat (5) @(negedge clk);
    rd(0, 3'd0, "R2 hold no tick", 32'd10);

    // R7 restart mode, R10 flag
    wr(0, 3'd3, 32'h0);
    wr(0, 3'd4, 32'd3);
    wr(0, 3'd0, 32'h0);
    ticks(10);
    rd(0, 3'd0, "R7 restart at compare", 32'd2);
    rd(0, 3'd3, "R10 flag set", 32'h0001_0000);
    wr(0, 3'd3, 32'h0);
    rd(0, 3'd3, "R10 zero write keeps flag", 32'h0001_0000);
    wr(0, 3'd3, 32'h0001_0000);
    rd(0, 3'd3, "R10 flag cleared", 32'h0);

    // R7 free-running mode
    wr(0, 3'd3, 32'h0000_8000);
    wr(0, 3'd0, 32'h0);
    ticks(10);
    rd(0, 3'd0, "R7 runs past compare", 32'd10);
    wr(0, 3'd3, 32'h0001_8000);

    // R4 snapshot across a low-half wrap
    wr(0, 3'd0, 32'hFFFF_FFFE);
    wr(0, 3'd1, 32'd4);
    ticks(3);
    rd(0, 3'd0, "R4 low after wrap", 32'd1);
    rd(0, 3'd2, "R4 snapshot after wrap", 32'd5);
    rd(0, 3'd1, "R4 high after wrap", 32'd5);

    // R5 torn read by two interleaved readers
    wr(0, 3'd0, 32'hFFFF_FFFF);
    wr(0, 3'd1, 32'd4);
    rd(0, 3'd0, "R5 reader A low", 32'hFFFF_FFFF);
    a_lo = 32'hFFFF_FFFF;
    ticks(1);
    rd(0, 3'd0, "R5 reader B low", 32'h0);
    bus(0, 1'b0, 3'd2, 32'h0, a_hi);
    check("R5 reader A sees new high", a_hi, 32'd5);
    check("R5 torn value 2^32 high",
          32'({a_hi, a_lo} - {32'd4, 32'hFFFF_FFFF} == 64'h1_0000_0000), 32'd1);

    // R6 write wins over a same-cycle tick
    tick = 1'b1;
    wr(0, 3'd0, 32'd100);
    tick = 1'b0;
    rd(0, 3'd0, "R6 load beats tick", 32'd100);

    // R9 enable set/clear
    wr(0, 3'd5, 32'h0000_7FFF);
    rd(0, 3'd7, "R9 set other bits no effect", 32'h0000_8000);
    wr(0, 3'd6, 32'h0000_7FFF);
    rd(0, 3'd7, "R9 clear zero no effect", 32'h0000_8000);
    wr(0, 3'd6, 32'h0000_8000);
    rd(0, 3'd7, "R9 cleared", 32'h0);
    ticks(5);
    rd(0, 3'd0, "R9 stopped counter holds", 32'd100);
    wr(0, 3'd5, 32'h0);
    rd(0, 3'd7, "R9 set zero no effect", 32'h0);

    // R11 32-bit build
    wr(1, 3'd1, 32'hFFFF_FFFE);
    wr(1, 3'd5, 32'h0000_8000);
    ticks(3);
    rd(1, 3'd1, "R11 narrow count wraps", 32'd1);
    rd(1, 3'd0, "R11 narrow low reads zero", 32'h0);
    rd(1, 3'd2, "R11 narrow snapshot zero", 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule